// File: doc/BRIEF.md
# Interrupt Redirection Register File

This block is the register side of an interrupt routing controller. A bus master sees only two 32-bit locations: an index register and a data window. The value last written to the index picks which internal register the window reads or writes. Behind the window are three control registers: a controller identifier, a read-only version and capacity word, and an arbitration word. After them comes a table with one 64-bit routing entry per interrupt input pin. Each entry is reached as a low half and a high half at two consecutive indices.

The routing fields of every pin (vector, delivery mode, destination mode, polarity, trigger mode, mask and destination) are driven out to the delivery logic in parallel. Delivery status and remote request flags come in from that logic. They appear in the low half of each entry and cannot be written from the bus. Software writes the high half first and the low half last. A high-half write is held in a per-pin staging field, and it reaches the destination output only when the low half of the same pin is written. The delivery logic therefore never sees an entry that is only half-written.

Top module: `ioredir_regfile`

## Requirements
- R1: After reset the index is 0, the identifier is 0, every pin's mask output is 1, and every other routing output is 0.
- R2: A write at byte offset 0x00 loads bus_wdata[7:0] into the index. A read at 0x00 returns the index zero-extended to 32 bits.
- R3: At index 0 the window holds a writable 4-bit identifier in bits [27:24]. All other bits read 0.
- R4: At index 1 the window reads 0x00178011: version 0x11 in [7:0], a request flag of 1 in bit 15, and the highest entry number 23 (pin count minus one) in [23:16]. Writes to it are ignored.
- R5: Because the version is at least 0x10, index 2 exists. It reads the identifier in bits [27:24] and ignores writes.
- R6: Pin n's low half sits at index 0x10+2n and its high half at 0x11+2n. Low-half layout: vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], remote request [14], trigger [15], mask [16], all other bits reading 0. High-half layout: destination [31:24], all other bits reading 0.
- R7: A high-half write is returned by reads of that high half at once. It does not change pin_dest until the low half of the same pin is written, which copies the staged destination to the output.
- R8: Low-half bits 12 and 14 always read the live dlv_busy and rem_irr inputs of that pin, and bus writes to those bits have no effect.
- R9: The window reads 0 at indices 3 to 0x0F and 0x40 to 0xFF, and writes there change no state. Every byte offset other than 0x00 and 0x10 also reads 0 and ignores writes.
- R10: A low-half write updates that pin's mask and routing outputs on the clock edge that takes the write. No other pin is affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current offset |
| bus_addr | input | 5 | Byte offset (0x00 index, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset, combinational |
| dlv_busy | input | 24 | Per-pin delivery status from delivery logic |
| rem_irr | input | 24 | Per-pin remote request flag from delivery logic |
| pin_mask | output | 24 | Per-pin mask |
| pin_vector | output | 192 | Per-pin vector, 8 bits each, pin n at [8n+7:8n] |
| pin_dmode | output | 72 | Per-pin delivery mode, 3 bits each |
| pin_dstmode | output | 24 | Per-pin destination mode |
| pin_pol | output | 24 | Per-pin input polarity (1 = active low) |
| pin_trig | output | 24 | Per-pin trigger mode (1 = level) |
| pin_dest | output | 192 | Per-pin committed destination, 8 bits each |

## Verification
The properties assume that bus_addr, bus_wr and bus_wdata are stable around each rising edge. They also assume that the status inputs feeding a low-half read do not change between the read and the sampling point. The stimulus meets both by changing every input only a short delay after a rising edge. The destination-hold property also assumes that a high-half write and a low-half write never arrive in the same cycle. The single-write-per-cycle bus guarantees this, and the stimulus separates every access by an idle cycle.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;

    localparam int ABITS   = 5;
    localparam int IDXW    = 8;
    localparam logic [ABITS-1:0] OFS_INDEX  = 5'h00;
    localparam logic [ABITS-1:0] OFS_WINDOW = 5'h10;
    localparam logic [IDXW-1:0]  TABLE_BASE = 8'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ID,
        SEL_VER,
        SEL_ARB,
        SEL_LO,
        SEL_HI
    } sel_e;

    // Routing fields kept per pin (status bits are live inputs, not stored).
    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] dmode;
        logic       dstmode;
        logic       pol;
        logic       trig;
        logic       mask;
    } route_t;

    localparam route_t ROUTE_RESET = '{vector: 8'h00, dmode: 3'h0, dstmode: 1'b0,
                                       pol: 1'b0, trig: 1'b0, mask: 1'b1};

endpackage

// File: rtl/ioredir_decode.sv
module ioredir_decode
    import ioredir_pkg::*;
#(
    parameter int          NPINS   = 24,
    parameter logic [7:0]  VERSION = 8'h11,
    localparam int         PINW    = $clog2(NPINS)
) (
    input  logic [IDXW-1:0] idx,
    output sel_e            sel,
    output logic [PINW-1:0] pin
);

    localparam int TABLE_END = int'(TABLE_BASE) + 2 * NPINS;
    localparam bit HAS_ARB   = (VERSION >= 8'h10);

    logic [IDXW-1:0] rel;

    always_comb begin
        rel = idx - TABLE_BASE;
        pin = PINW'(rel >> 1);
        sel = SEL_NONE;
        if (idx == 8'd0) begin
            sel = SEL_ID;
        end else if (idx == 8'd1) begin
            sel = SEL_VER;
        end else if (idx == 8'd2 && HAS_ARB) begin
            sel = SEL_ARB;
        end else if (int'(idx) >= int'(TABLE_BASE) && int'(idx) < TABLE_END) begin
            sel = idx[0] ? SEL_HI : SEL_LO;
        end
    end

endmodule

// File: rtl/ioredir_entry.sv
module ioredir_entry
    import ioredir_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  route_t      route_in,
    input  logic [7:0]  dest_in,
    input  logic        busy_in,
    input  logic        irr_in,
    output logic [31:0] lo_word,
    output logic [31:0] hi_word,
    output route_t      route,
    output logic [7:0]  dest
);

    typedef struct packed {
        route_t     route;
        logic [7:0] staged;
        logic [7:0] dest;
    } ent_t;

    ent_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hi) begin
            st_d.staged = dest_in;
        end
        if (wr_lo) begin
            st_d.route = route_in;
            st_d.dest  = st_q.staged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{route: ROUTE_RESET, staged: 8'h00, dest: 8'h00};
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_word = {15'h0, st_q.route.mask, st_q.route.trig, irr_in, st_q.route.pol,
                      busy_in, st_q.route.dstmode, st_q.route.dmode, st_q.route.vector};
    assign hi_word = {st_q.staged, 24'h0};
    assign route   = st_q.route;
    assign dest    = st_q.dest;

endmodule

// File: rtl/ioredir_regfile.sv
module ioredir_regfile
    import ioredir_pkg::*;
#(
    parameter int         NPINS    = 24,
    parameter logic [7:0] VERSION  = 8'h11,
    parameter logic       PRQ_FLAG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [4:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NPINS-1:0]   dlv_busy,
    input  logic [NPINS-1:0]   rem_irr,
    output logic [NPINS-1:0]   pin_mask,
    output logic [NPINS*8-1:0] pin_vector,
    output logic [NPINS*3-1:0] pin_dmode,
    output logic [NPINS-1:0]   pin_dstmode,
    output logic [NPINS-1:0]   pin_pol,
    output logic [NPINS-1:0]   pin_trig,
    output logic [NPINS*8-1:0] pin_dest
);

    localparam int         PINW    = $clog2(NPINS);
    localparam logic [7:0] MAX_ENT = 8'(NPINS - 1);

    typedef struct packed {
        logic [IDXW-1:0] idx;
        logic [3:0]      id;
    } top_t;

    top_t            st_d, st_q;
    sel_e            sel;
    logic [PINW-1:0] pin;
    logic            idx_wr, win_wr;
    logic [IDXW-1:0] cur_index;
    route_t          wr_route;
    logic [31:0]     lo_w [NPINS];
    logic [31:0]     hi_w [NPINS];
    logic [10:0]     wdata_unused;

    assign cur_index    = st_q.idx;
    assign idx_wr       = bus_wr && (bus_addr == OFS_INDEX);
    assign win_wr       = bus_wr && (bus_addr == OFS_WINDOW);
    assign wdata_unused = {bus_wdata[23:17], bus_wdata[14], bus_wdata[12], 2'b00};
    assign wr_route     = '{vector: bus_wdata[7:0], dmode: bus_wdata[10:8],
                            dstmode: bus_wdata[11], pol: bus_wdata[13],
                            trig: bus_wdata[15], mask: bus_wdata[16]};

    ioredir_decode #(.NPINS(NPINS), .VERSION(VERSION)) u_dec (
        .idx (st_q.idx),
        .sel (sel),
        .pin (pin)
    );

    always_comb begin
        st_d = st_q;
        if (idx_wr) begin
            st_d.idx = bus_wdata[IDXW-1:0];
        end
        if (win_wr && sel == SEL_ID) begin
            st_d.id = bus_wdata[27:24];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        route_t     r;
        logic [7:0] d;

        ioredir_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (win_wr && sel == SEL_LO && pin == PINW'(g)),
            .wr_hi    (win_wr && sel == SEL_HI && pin == PINW'(g)),
            .route_in (wr_route),
            .dest_in  (bus_wdata[31:24]),
            .busy_in  (dlv_busy[g]),
            .irr_in   (rem_irr[g]),
            .lo_word  (lo_w[g]),
            .hi_word  (hi_w[g]),
            .route    (r),
            .dest     (d)
        );

        assign pin_mask[g]        = r.mask;
        assign pin_vector[g*8+:8] = r.vector;
        assign pin_dmode[g*3+:3]  = r.dmode;
        assign pin_dstmode[g]     = r.dstmode;
        assign pin_pol[g]         = r.pol;
        assign pin_trig[g]        = r.trig;
        assign pin_dest[g*8+:8]   = d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_INDEX) begin
            bus_rdata = {{(32-IDXW){1'b0}}, st_q.idx};
        end else if (bus_addr == OFS_WINDOW) begin
            case (sel)
                SEL_ID, SEL_ARB: bus_rdata[27:24] = st_q.id;
                SEL_VER:         bus_rdata = {8'h00, MAX_ENT, PRQ_FLAG, 7'h00, VERSION};
                SEL_LO:          bus_rdata = lo_w[pin];
                SEL_HI:          bus_rdata = hi_w[pin];
                default:         bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ioredir_regfile_chk.sv
module ioredir_regfile_chk #(
    parameter int NPINS = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [4:0]         bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [NPINS-1:0]   dlv_busy,
    input logic [NPINS-1:0]   rem_irr,
    input logic [NPINS-1:0]   pin_mask,
    input logic [NPINS*8-1:0] pin_dest,
    input logic [7:0]         cur_index
);

    localparam int PINW = $clog2(NPINS);

    logic [PINW-1:0] cpin;
    logic            in_tab;
    logic            lo_sel;

    assign cpin   = PINW'((cur_index - 8'h10) >> 1);
    assign in_tab = (int'(cur_index) >= 16) && (int'(cur_index) < 16 + 2 * NPINS);
    assign lo_sel = (bus_addr == 5'h10) && in_tab && !cur_index[0];

    // R2: index write lands in the index on the next cycle
    a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'h00) |=> (cur_index == $past(bus_wdata[7:0])));

    // R4: version and capacity word is constant
    a_r4_version_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 5'h10 && cur_index == 8'd1) |-> (bus_rdata == 32'h0017_8011));

    // R7: destination outputs move only with a low-half write
    a_r7_dest_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && lo_sel) |=> $stable(pin_dest));

    // R8: status bits in a low-half read track the live inputs
    a_r8_status_live: assert property (@(posedge clk) disable iff (!rst_n)
        lo_sel |-> (bus_rdata[12] == dlv_busy[cpin] && bus_rdata[14] == rem_irr[cpin]));

    // R9: offsets outside the index and window read zero
    a_r9_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 5'h00 && bus_addr != 5'h10) |-> (bus_rdata == 32'h0));

    // R10: low-half write sets the pin's mask from bit 16
    a_r10_mask_update: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && lo_sel) |=> (pin_mask[$past(cpin)] == $past(bus_wdata[16])));

endmodule

bind ioredir_regfile ioredir_regfile_chk #(.NPINS(NPINS)) u_chk (.*);

// File: tb/ioredir_regfile_test.sv
module ioredir_regfile_test;

    localparam int NP = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [4:0]     bus_addr = 5'h0;
    logic [31:0]    bus_wdata = 32'h0;
    logic [31:0]    bus_rdata;
    logic [NP-1:0]  dlv_busy = '0;
    logic [NP-1:0]  rem_irr = '0;
    logic [NP-1:0]  pin_mask, pin_dstmode, pin_pol, pin_trig;
    logic [NP*8-1:0] pin_vector, pin_dest;
    logic [NP*3-1:0] pin_dmode;

    int    n_checks = 0;
    int    n_fails = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int m_idx, m_id;
    int m_vec[NP], m_dm[NP], m_dsm[NP], m_pol[NP], m_trig[NP], m_mask[NP];
    int m_stage[NP], m_dest[NP];

    always #5 clk = ~clk;

    ioredir_regfile uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dlv_busy(dlv_busy),
        .rem_irr(rem_irr), .pin_mask(pin_mask), .pin_vector(pin_vector),
        .pin_dmode(pin_dmode), .pin_dstmode(pin_dstmode), .pin_pol(pin_pol),
        .pin_trig(pin_trig), .pin_dest(pin_dest)
    );

    task automatic model_reset();
        m_idx = 0;
        m_id  = 0;
        for (int p = 0; p < NP; p++) begin
            m_vec[p] = 0; m_dm[p] = 0; m_dsm[p] = 0; m_pol[p] = 0;
            m_trig[p] = 0; m_mask[p] = 1; m_stage[p] = 0; m_dest[p] = 0;
        end
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else if (bus_wr && bus_addr == 5'h00) begin
            m_idx = int'(bus_wdata[7:0]);
        end else if (bus_wr && bus_addr == 5'h10) begin
            if (m_idx == 0) begin
                m_id = int'(bus_wdata[27:24]);
            end else if (m_idx >= 16 && m_idx < 16 + 2 * NP) begin
                automatic int p = (m_idx - 16) / 2;
                if (m_idx % 2 == 1) begin
                    m_stage[p] = int'(bus_wdata[31:24]);
                end else begin
                    m_vec[p]  = int'(bus_wdata[7:0]);
                    m_dm[p]   = int'(bus_wdata[10:8]);
                    m_dsm[p]  = int'(bus_wdata[11]);
                    m_pol[p]  = int'(bus_wdata[13]);
                    m_trig[p] = int'(bus_wdata[15]);
                    m_mask[p] = int'(bus_wdata[16]);
                    m_dest[p] = m_stage[p];
                end
            end
        end
    end

    function automatic logic [31:0] exp_rdata();
        logic [31:0] r = 32'h0;
        if (bus_addr == 5'h00) begin
            r = 32'(m_idx);
        end else if (bus_addr == 5'h10) begin
            if (m_idx == 0 || m_idx == 2) begin
                r = 32'(m_id) << 24;
            end else if (m_idx == 1) begin
                r = 32'h0017_8011;
            end else if (m_idx >= 16 && m_idx < 16 + 2 * NP) begin
                automatic int p = (m_idx - 16) / 2;
                if (m_idx % 2 == 1) begin
                    r = 32'(m_stage[p]) << 24;
                end else begin
                    r = 32'(m_vec[p]) | (32'(m_dm[p]) << 8) | (32'(m_dsm[p]) << 11)
                      | (32'(dlv_busy[p]) << 12) | (32'(m_pol[p]) << 13)
                      | (32'(rem_irr[p]) << 14) | (32'(m_trig[p]) << 15)
                      | (32'(m_mask[p]) << 16);
                end
            end
        end
        return r;
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            logic [NP-1:0]   e_mask, e_dsm, e_pol, e_trig;
            logic [NP*8-1:0] e_vec, e_dest;
            logic [NP*3-1:0] e_dm;
            logic [31:0]     e_rd;
            for (int p = 0; p < NP; p++) begin
                e_mask[p] = m_mask[p][0];
                e_dsm[p]  = m_dsm[p][0];
                e_pol[p]  = m_pol[p][0];
                e_trig[p] = m_trig[p][0];
                e_vec[p*8+:8]  = 8'(m_vec[p]);
                e_dest[p*8+:8] = 8'(m_dest[p]);
                e_dm[p*3+:3]   = 3'(m_dm[p]);
            end
            e_rd = exp_rdata();
            n_checks++;
            if (bus_rdata !== e_rd) begin
                n_fails++;
                $display("FAIL %s rdata actual=%08h expected=%08h (idx=%0d addr=%0h)",
                         cur_req, bus_rdata, e_rd, m_idx, bus_addr);
            end
            n_checks++;
            if ({pin_mask, pin_dstmode, pin_pol, pin_trig, pin_vector, pin_dest, pin_dmode} !==
                {e_mask, e_dsm, e_pol, e_trig, e_vec, e_dest, e_dm}) begin
                n_fails++;
                $display("FAIL %s outputs actual mask=%h dest=%h vec=%h expected mask=%h dest=%h vec=%h",
                         cur_req, pin_mask, pin_dest, pin_vector, e_mask, e_dest, e_vec);
            end
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic look(input logic [4:0] a);
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #2;
    endtask

    task automatic point(input int ix);
        bus_write(5'h00, 32'hA5A5_A500 | 32'(ix));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired in %s", cur_req);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        look(5'h00);
        look(5'h10);

        // R2: index load and readback
        cur_req = "R2";
        bus_write(5'h00, 32'hABCD_EF05);
        look(5'h00);
        bus_write(5'h00, 32'h0000_002A);
        look(5'h00);

        // R3: identifier register
        cur_req = "R3";
        point(0);
        bus_write(5'h10, 32'hFFFF_FFFF);
        look(5'h10);
        bus_write(5'h10, 32'h0500_0000);
        look(5'h10);

        // R4: version word is read-only
        cur_req = "R4";
        point(1);
        look(5'h10);
        bus_write(5'h10, 32'hFFFF_FFFF);
        look(5'h10);

        // R5: arbitration word mirrors the identifier, ignores writes
        cur_req = "R5";
        point(2);
        look(5'h10);
        bus_write(5'h10, 32'h0000_0000);
        point(0);
        look(5'h10);

        // R9: unimplemented indices and offsets
        cur_req = "R9";
        for (int k = 0; k < 4; k++) begin
            automatic int ix = (k == 0) ? 3 : (k == 1) ? 15 : (k == 2) ? 64 : 255;
            point(ix);
            bus_write(5'h10, 32'hFFFF_FFFF);
            look(5'h10);
        end
        point(16);
        for (int k = 0; k < 5; k++) begin
            automatic logic [4:0] a = (k == 0) ? 5'h04 : (k == 1) ? 5'h08 :
                                      (k == 2) ? 5'h0C : (k == 3) ? 5'h14 : 5'h1F;
            bus_write(a, 32'hFFFF_FFFF);
            look(a);
        end
        point(0);
        look(5'h10);

        // R7: staged high half, commit on low half
        cur_req = "R7";
        point(16 + 1 + 16);
        bus_write(5'h10, 32'hC3FF_FFFF);
        look(5'h10);
        point(16 + 16);
        look(5'h10);
        point(16 + 2 * 3);
        bus_write(5'h10, 32'h0001_0040);
        bus_write(5'h10, 32'h0001_0041);
        point(16 + 16);
        bus_write(5'h10, 32'h0000_A155);
        look(5'h10);

        // R6 / R10: every pin, both halves
        cur_req = "R6";
        for (int p = 0; p < NP; p++) begin
            point(17 + 2 * p);
            bus_write(5'h10, (32'(p * 7 + 3) << 24) | 32'h00FF_FFFF);
            point(16 + 2 * p);
            bus_write(5'h10, 32'hFFFE_0000 | (32'(p % 2) << 16) | 32'((p * 1237) & 16'hAFFF));
            look(5'h10);
        end
        cur_req = "R10";
        for (int p = 0; p < NP; p += 5) begin
            point(16 + 2 * p);
            bus_write(5'h10, 32'h0001_0000);
            look(5'h10);
            bus_write(5'h10, 32'h0000_8020);
            look(5'h10);
        end

        // R8: live status bits, write-protected
        cur_req = "R8";
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #2;
            dlv_busy = 24'h5A_3C96 ^ (24'(k) * 24'h13_5791);
            rem_irr  = 24'hC3_0F69 ^ (24'(k) * 24'h2468AC);
            for (int p = 0; p < NP; p += 7) begin
                point(16 + 2 * p);
                look(5'h10);
            end
        end
        point(16 + 2 * 23);
        bus_write(5'h10, 32'h0000_5000);
        look(5'h10);
        @(posedge clk); #2;
        dlv_busy = ~dlv_busy;
        rem_irr  = ~rem_irr;
        look(5'h10);

        finish_run();
    end

endmodule